// File: doc/BRIEF.md
# Raster Line and Frame Timing Generator

This block produces the horizontal and vertical timing of a raster display. A fast master clock is divided down to a slow pixel-cell enable. On each enable a horizontal position counter advances, and each time that counter wraps a vertical line counter advances. From the two counts the block decodes an active-low horizontal sync and an active-low composite sync. It also produces a fetch window, which tells the video memory fetcher when screen bytes are needed, and a pixel enable, which tells the colour stage when a pixel is shown rather than blanked.

Two run-time controls sit on top of the fixed frame. The first is a bottom-band blank count. It forces the final N lines of the active area to blank while their memory reads still take place, so that a display scrolled by a part of a character row can hide the partial row at its foot. The second is a suspend bit. It blanks every pixel and also withdraws all fetch requests, so that software can rebuild screen memory without the video side reading it. Both controls are written through a small write port into a pending copy. They are moved into the working copy only at the frame boundary, so a frame is never drawn half with the old settings and half with the new ones.

With the default parameters the master clock runs at 16 MHz and is divided by 8 to 2 MHz. A line is 128 enables (64 us), of which 80 are the fetch window. A frame is 312 lines, of which 256 are active.

Top module: `raster_timing`

## Requirements
- R1: While reset is held and immediately after it, h_count and v_count are 0, hsync_n and csync_n are 1, and the blank count and suspend are 0, so fetch_req and pixel_en are 1 at position (0,0).
- R2: tick is high for one clock out of every CLK_DIV clocks. It is first high CLK_DIV-1 clocks after reset is released. The counters change only on clocks where tick is high.
- R3: On each tick h_count steps by one and wraps from H_TOTAL-1 to 0. v_count steps by one only on the tick where h_count wraps, and wraps from V_TOTAL-1 to 0 on that same tick.
- R4: fetch_req is 1 exactly when h_count < H_ACTIVE, v_count < V_ACTIVE and the working suspend bit is 0.
- R5: hsync_n is 0 exactly when HS_START <= h_count < HS_START+HS_LEN. It keeps running while suspend is set.
- R6: csync_n is 0 exactly when hsync_n is 0 or VS_START <= v_count < VS_START+VS_LEN.
- R7: With a working blank count N < V_ACTIVE, pixel_en equals fetch_req except on lines v_count >= V_ACTIVE-N, where pixel_en is 0 while fetch_req stays 1.
- R8: A working blank count >= V_ACTIVE blanks every active line: pixel_en is 0 throughout, while fetch_req is unaffected.
- R9: With the working suspend bit set, fetch_req and pixel_en are 0 at every position.
- R10: A write with wr_en=1 stores wr_data as the blank count when wr_sel=0, or stores wr_data[0] as suspend when wr_sel=1. The stored value takes effect on the tick where both counters wrap to 0, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Control write strobe, one clock per write |
| wr_sel | input | 1 | Write target: 0 blank-line count, 1 suspend bit |
| wr_data | input | DATA_W | Write value (bit 0 only for suspend) |
| tick | output | 1 | Divided pixel-cell enable |
| h_count | output | $clog2(H_TOTAL) | Horizontal position in enables |
| v_count | output | $clog2(V_TOTAL) | Line number within the frame |
| hsync_n | output | 1 | Horizontal sync, low during sync |
| csync_n | output | 1 | Composite sync, low during horizontal or vertical sync |
| fetch_req | output | 1 | Screen memory fetch window |
| pixel_en | output | 1 | Pixel shown (0 forces blank) |

## Verification
The bench builds the block with CLK_DIV=2, a 16-enable line with 10 fetch positions and sync at positions 12 and 13, and a 20-line frame with 12 active lines and vertical sync on lines 15 and 16. It uses DATA_W=5. With these values a whole frame lasts 640 clocks. Every wrap, both sync edges and the end of the active window are therefore reached in a few thousand cycles. The 5-bit write port can also carry a blank count of 20, which is above the active height and so tests the saturating case. Control writes are placed in the middle of a frame, so the bench can show that the old setting still holds until the next frame begins.

// File: rtl/raster_pkg.sv
package raster_pkg;

    // Write-port target select.
    typedef enum logic {
        REG_BLANK   = 1'b0,
        REG_SUSPEND = 1'b1
    } reg_sel_e;

    // Position flags derived from the counters.
    typedef struct packed {
        logic h_sync;
        logic v_sync;
        logic in_window;
        logic in_band;
    } pos_flags_t;

endpackage

// File: rtl/raster_clkdiv.sv
module raster_clkdiv #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);

    generate
        if (DIV <= 1) begin : g_pass
            // No division: every clock is a cell.
            assign tick = 1'b1;
        end else begin : g_div
            localparam int DW = $clog2(DIV);
            typedef struct packed {
                logic [DW-1:0] cnt;
            } div_st_t;

            div_st_t s_d, s_q;

            always_comb begin
                s_d = s_q;
                if (s_q.cnt == DW'(DIV - 1)) begin
                    s_d.cnt = '0;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    s_q <= '0;
                end else begin
                    s_q <= s_d;
                end
            end

            assign tick = (s_q.cnt == DW'(DIV - 1));
        end
    endgenerate

endmodule

// File: rtl/raster_counter.sv
module raster_counter #(
    parameter  int LIMIT = 128,
    localparam int CW    = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    output logic [CW-1:0] count,
    output logic          wrap
);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } cnt_st_t;

    cnt_st_t s_d, s_q;
    logic    at_last;

    assign at_last = (s_q.cnt == CW'(LIMIT - 1));

    always_comb begin
        s_d = s_q;
        if (step) begin
            if (at_last) begin
                s_d.cnt = '0;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign count = s_q.cnt;
    assign wrap  = step & at_last;

endmodule

// File: rtl/raster_cfg.sv
module raster_cfg
    import raster_pkg::*;
#(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              apply,
    output logic [DATA_W-1:0] blank_lines,
    output logic              suspend
);

    typedef struct packed {
        logic [DATA_W-1:0] pend_blank;
        logic              pend_susp;
        logic [DATA_W-1:0] act_blank;
        logic              act_susp;
    } cfg_st_t;

    cfg_st_t  s_d, s_q;
    reg_sel_e sel;

    assign sel = reg_sel_e'(wr_sel);

    always_comb begin
        s_d = s_q;
        // Working copy loads from the pending copy as it stood before this edge.
        if (apply) begin
            s_d.act_blank = s_q.pend_blank;
            s_d.act_susp  = s_q.pend_susp;
        end
        if (wr_en) begin
            case (sel)
                REG_BLANK:   s_d.pend_blank = wr_data;
                REG_SUSPEND: s_d.pend_susp  = wr_data[0];
                default:     s_d.pend_susp  = s_q.pend_susp;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign blank_lines = s_q.act_blank;
    assign suspend     = s_q.act_susp;

endmodule

// File: rtl/raster_decode.sv
module raster_decode
    import raster_pkg::*;
#(
    parameter int H_ACTIVE = 80,
    parameter int HS_START = 96,
    parameter int HS_LEN   = 9,
    parameter int V_ACTIVE = 256,
    parameter int VS_START = 274,
    parameter int VS_LEN   = 3,
    parameter int HW       = 7,
    parameter int VW       = 9,
    parameter int DATA_W   = 9
) (
    input  logic [HW-1:0]     h,
    input  logic [VW-1:0]     v,
    input  logic [DATA_W-1:0] blank_lines,
    input  logic              suspend,
    output logic              hsync_n,
    output logic              csync_n,
    output logic              fetch_req,
    output logic              pixel_en
);

    pos_flags_t flags;
    int         h_i;
    int         v_i;
    int         blank_i;
    int         band_start;

    assign h_i     = int'(h);
    assign v_i     = int'(v);
    assign blank_i = int'(blank_lines);

    // First hidden line; a count at or above the active height hides them all.
    assign band_start = (blank_i >= V_ACTIVE) ? 0 : (V_ACTIVE - blank_i);

    always_comb begin
        flags.h_sync    = (h_i >= HS_START) && (h_i < HS_START + HS_LEN);
        flags.v_sync    = (v_i >= VS_START) && (v_i < VS_START + VS_LEN);
        flags.in_window = (h_i < H_ACTIVE) && (v_i < V_ACTIVE);
        flags.in_band   = (v_i >= band_start);
    end

    assign hsync_n   = ~flags.h_sync;
    assign csync_n   = ~(flags.h_sync | flags.v_sync);
    assign fetch_req = flags.in_window & ~suspend;
    assign pixel_en  = flags.in_window & ~suspend & ~flags.in_band;

endmodule

// File: rtl/raster_timing.sv
module raster_timing #(
    parameter  int CLK_DIV  = 8,
    parameter  int H_TOTAL  = 128,
    parameter  int H_ACTIVE = 80,
    parameter  int HS_START = 96,
    parameter  int HS_LEN   = 9,
    parameter  int V_TOTAL  = 312,
    parameter  int V_ACTIVE = 256,
    parameter  int VS_START = 274,
    parameter  int VS_LEN   = 3,
    parameter  int DATA_W   = 9,
    localparam int HW       = (H_TOTAL > 1) ? $clog2(H_TOTAL) : 1,
    localparam int VW       = (V_TOTAL > 1) ? $clog2(V_TOTAL) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic              tick,
    output logic [HW-1:0]     h_count,
    output logic [VW-1:0]     v_count,
    output logic              hsync_n,
    output logic              csync_n,
    output logic              fetch_req,
    output logic              pixel_en
);

    logic              h_wrap;
    logic              v_wrap;
    logic [DATA_W-1:0] blank_lines;
    logic              suspend;

    raster_clkdiv #(.DIV(CLK_DIV)) u_div (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    raster_counter #(.LIMIT(H_TOTAL)) u_hcnt (
        .clk   (clk),
        .rst   (rst),
        .step  (tick),
        .count (h_count),
        .wrap  (h_wrap)
    );

    raster_counter #(.LIMIT(V_TOTAL)) u_vcnt (
        .clk   (clk),
        .rst   (rst),
        .step  (h_wrap),
        .count (v_count),
        .wrap  (v_wrap)
    );

    raster_cfg #(.DATA_W(DATA_W)) u_cfg (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wr_sel      (wr_sel),
        .wr_data     (wr_data),
        .apply       (v_wrap),
        .blank_lines (blank_lines),
        .suspend     (suspend)
    );

    raster_decode #(
        .H_ACTIVE (H_ACTIVE),
        .HS_START (HS_START),
        .HS_LEN   (HS_LEN),
        .V_ACTIVE (V_ACTIVE),
        .VS_START (VS_START),
        .VS_LEN   (VS_LEN),
        .HW       (HW),
        .VW       (VW),
        .DATA_W   (DATA_W)
    ) u_dec (
        .h           (h_count),
        .v           (v_count),
        .blank_lines (blank_lines),
        .suspend     (suspend),
        .hsync_n     (hsync_n),
        .csync_n     (csync_n),
        .fetch_req   (fetch_req),
        .pixel_en    (pixel_en)
    );

endmodule

// File: rtl/raster_timing_chk.sv
module raster_timing_chk #(
    parameter int CLK_DIV  = 8,
    parameter int H_TOTAL  = 128,
    parameter int H_ACTIVE = 80,
    parameter int V_TOTAL  = 312,
    parameter int V_ACTIVE = 256,
    parameter int HW       = 7,
    parameter int VW       = 9,
    parameter int DATA_W   = 9
) (
    input logic              clk,
    input logic              rst,
    input logic              tick,
    input logic [HW-1:0]     h,
    input logic [VW-1:0]     v,
    input logic              hsync_n,
    input logic              csync_n,
    input logic              fetch_req,
    input logic              pixel_en,
    input logic              frame_end,
    input logic [DATA_W-1:0] act_blank,
    input logic              act_susp
);

    generate
        if (CLK_DIV > 1) begin : g_gap
            assert_tick_gap_R2: assert property (@(posedge clk) disable iff (rst)
                tick |=> !tick);
        end
    endgenerate

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !tick |=> ($stable(h) && $stable(v)));

    assert_h_step_R3: assert property (@(posedge clk) disable iff (rst)
        (tick && (h != HW'(H_TOTAL - 1))) |=> (h == HW'($past(h) + 1'b1)));

    assert_h_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (tick && (h == HW'(H_TOTAL - 1))) |=> (h == '0));

    assert_v_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (tick && (h != HW'(H_TOTAL - 1))) |=> $stable(v));

    assert_v_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (tick && (h == HW'(H_TOTAL - 1)) && (v == VW'(V_TOTAL - 1))) |=> (v == '0));

    assert_window_R4: assert property (@(posedge clk) disable iff (rst)
        fetch_req |-> ((int'(h) < H_ACTIVE) && (int'(v) < V_ACTIVE)));

    assert_csync_R6: assert property (@(posedge clk) disable iff (rst)
        !hsync_n |-> !csync_n);

    assert_subset_R7: assert property (@(posedge clk) disable iff (rst)
        pixel_en |-> fetch_req);

    assert_suspend_R9: assert property (@(posedge clk) disable iff (rst)
        act_susp |-> (!fetch_req && !pixel_en));

    assert_apply_R10: assert property (@(posedge clk) disable iff (rst)
        !frame_end |=> ($stable(act_blank) && $stable(act_susp)));

endmodule

bind raster_timing raster_timing_chk #(
    .CLK_DIV  (CLK_DIV),
    .H_TOTAL  (H_TOTAL),
    .H_ACTIVE (H_ACTIVE),
    .V_TOTAL  (V_TOTAL),
    .V_ACTIVE (V_ACTIVE),
    .HW       (HW),
    .VW       (VW),
    .DATA_W   (DATA_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .h         (h_count),
    .v         (v_count),
    .hsync_n   (hsync_n),
    .csync_n   (csync_n),
    .fetch_req (fetch_req),
    .pixel_en  (pixel_en),
    .frame_end (v_wrap),
    .act_blank (blank_lines),
    .act_susp  (suspend)
);

// File: tb/sim_raster_timing.sv
`timescale 1ns/1ps
module sim_raster_timing;

    localparam int D   = 2;
    localparam int H   = 16;
    localparam int HA  = 10;
    localparam int HSS = 12;
    localparam int HSL = 2;
    localparam int V   = 20;
    localparam int VA  = 12;
    localparam int VSS = 15;
    localparam int VSL = 2;
    localparam int DW  = 5;
    localparam int HW  = $clog2(H);
    localparam int VW  = $clog2(V);
    localparam int FR  = H * V;

    typedef struct packed {
        int   t;
        int   h;
        int   v;
        logic hs;
        logic cs;
        logic f;
        logic d;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{0,   0,  0,  1'b1, 1'b1, 1'b1, 1'b1},
        '{9,   9,  0,  1'b1, 1'b1, 1'b1, 1'b1},
        '{10,  10, 0,  1'b1, 1'b1, 1'b0, 1'b0},
        '{12,  12, 0,  1'b0, 1'b0, 1'b0, 1'b0},
        '{13,  13, 0,  1'b0, 1'b0, 1'b0, 1'b0},
        '{14,  14, 0,  1'b1, 1'b1, 1'b0, 1'b0},
        '{15,  15, 0,  1'b1, 1'b1, 1'b0, 1'b0},
        '{16,  0,  1,  1'b1, 1'b1, 1'b1, 1'b1},
        '{181, 5,  11, 1'b1, 1'b1, 1'b1, 1'b1},
        '{192, 0,  12, 1'b1, 1'b1, 1'b0, 1'b0},
        '{243, 3,  15, 1'b1, 1'b0, 1'b0, 1'b0},
        '{252, 12, 15, 1'b0, 1'b0, 1'b0, 1'b0},
        '{271, 15, 16, 1'b1, 1'b0, 1'b0, 1'b0},
        '{272, 0,  17, 1'b1, 1'b1, 1'b0, 1'b0},
        '{319, 15, 19, 1'b1, 1'b1, 1'b0, 1'b0},
        '{320, 0,  0,  1'b1, 1'b1, 1'b1, 1'b1}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic          wr_sel = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          tick;
    logic [HW-1:0] h_count;
    logic [VW-1:0] v_count;
    logic          hsync_n;
    logic          csync_n;
    logic          fetch_req;
    logic          pixel_en;

    int n_checks = 0;
    int n_fails  = 0;
    int n_edges  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        if (rst) n_edges <= 0;
        else     n_edges <= n_edges + 1;
    end

    raster_timing #(
        .CLK_DIV (D),  .H_TOTAL (H),  .H_ACTIVE (HA), .HS_START (HSS),
        .HS_LEN  (HSL), .V_TOTAL (V), .V_ACTIVE (VA), .VS_START (VSS),
        .VS_LEN  (VSL), .DATA_W  (DW)
    ) u0 (
        .clk (clk), .rst (rst), .wr_en (wr_en), .wr_sel (wr_sel),
        .wr_data (wr_data), .tick (tick), .h_count (h_count),
        .v_count (v_count), .hsync_n (hsync_n), .csync_n (csync_n),
        .fetch_req (fetch_req), .pixel_en (pixel_en)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual %0d expected %0d at edge %0d", req, act, exp, n_edges);
        end
    endtask

    // Go to the falling edge where exactly t ticks have elapsed since reset.
    task automatic go_tick(input int t);
        while (n_edges < t * D) @(negedge clk);
        chk("R3 reachable", n_edges, t * D);
    endtask

    task automatic write_reg(input logic sel, input int data);
        wr_sel  = sel;
        wr_data = DW'(data);
        wr_en   = 1'b1;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic look(input string req, input int f, input int d);
        chk({req, " fetch_req"}, int'(fetch_req), f);
        chk({req, " pixel_en"},  int'(pixel_en),  d);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not complete");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 h_count", int'(h_count), 0);
        chk("R1 v_count", int'(v_count), 0);
        chk("R1 hsync_n", int'(hsync_n), 1);
        chk("R1 csync_n", int'(csync_n), 1);
        chk("R1 tick",    int'(tick),    0);
        look("R1", 1, 1);
        rst = 1'b0;

        // Frame 0: table walk over R3, R4, R5, R6
        for (int i = 0; i < NV; i++) begin
            go_tick(VEC[i].t);
            chk("R3 h_count", int'(h_count), VEC[i].h);
            chk("R3 v_count", int'(v_count), VEC[i].v);
            chk("R5 hsync_n", int'(hsync_n), int'(VEC[i].hs));
            chk("R6 csync_n", int'(csync_n), int'(VEC[i].cs));
            look("R4", int'(VEC[i].f), int'(VEC[i].d));
        end

        // R2: tick phase, counters hold between ticks
        chk("R2 tick low", int'(tick), 0);
        @(negedge clk);
        chk("R2 tick high", int'(tick), 1);
        chk("R2 h held", int'(h_count), 0);
        @(negedge clk);
        chk("R2 tick low again", int'(tick), 0);
        chk("R2 h stepped", int'(h_count), 1);

        // R7 / R10: blank count 3 written mid frame 1
        write_reg(1'b0, 3);
        go_tick(FR + 10 * 16 + 2);
        look("R10 old blank count", 1, 1);
        go_tick(2 * FR + 8 * 16);
        look("R7 line before band", 1, 1);
        go_tick(2 * FR + 9 * 16);
        look("R7 first band line", 1, 0);
        go_tick(2 * FR + 11 * 16 + 9);
        look("R7 last band cell", 1, 0);
        go_tick(2 * FR + 11 * 16 + 10);
        look("R7 past window", 0, 0);

        // R8: saturating count
        write_reg(1'b0, 20);
        go_tick(3 * FR);
        look("R8 top line", 1, 0);
        go_tick(3 * FR + 5 * 16 + 3);
        look("R8 mid line", 1, 0);

        // R9 / R10: suspend written mid frame 3
        write_reg(1'b0, 0);
        write_reg(1'b1, 1);
        go_tick(3 * FR + 6 * 16 + 4);
        look("R10 suspend pending", 1, 0);
        go_tick(4 * FR);
        look("R9 suspended top", 0, 0);
        go_tick(4 * FR + 3 * 16 + 5);
        look("R9 suspended mid", 0, 0);
        go_tick(4 * FR + 3 * 16 + 12);
        chk("R5 hsync_n during suspend", int'(hsync_n), 0);
        chk("R6 csync_n during suspend", int'(csync_n), 0);

        // R10: clearing suspend returns the display on the next frame
        write_reg(1'b1, 0);
        go_tick(4 * FR + 11 * 16 + 1);
        look("R10 still suspended", 0, 0);
        go_tick(5 * FR);
        look("R10 resumed", 1, 1);
        go_tick(5 * FR + 11 * 16 + 9);
        look("R10 no band", 1, 1);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule